// File: doc/BRIEF.md
# Isochronous Endpoint Frame Scheduler

This block schedules one device-side isochronous endpoint across bus (micro)frames. Software loads a descriptor with a packets-per-frame count and a transfer length, then pulses a prime strobe. The block holds that request back until the next start-of-frame pulse, so the descriptor is always tied to a whole frame. While the descriptor is live, the block tells the packet engine to send data on IN tokens and to accept data on OUT tokens. It counts completed packets against the per-frame count and tracks the bytes left in the transfer.

The endpoint never answers with a NAK. When it is not live, an IN token gets a zero-length packet and an OUT packet is dropped. The block raises a one-cycle retire strobe in two cases: when the per-frame count is met, or at a frame boundary that cuts a started frame short. The retire strobe comes with a status word holding an error summary and the residual length. A received CRC error is not retried. It is recorded in the status, and the packet still counts.

Top module: `iso_ep_sched`

## Requirements
- R1: A prime is accepted only when the endpoint is idle, cancel is low and the packets-per-frame count is nonzero. The visible prime bit `prime_bit_o` is high for exactly the one cycle after acceptance, and the endpoint becomes pending (`pend_o`=1).
- R2: A pending descriptor becomes live (`active_o`=1) only on a later start-of-frame pulse. A start-of-frame in the same cycle as the prime does not count, and tokens seen while pending are treated as unprimed.
- R3: An IN token while not live yields `tx_zlp_o`=1 and `tx_data_o`=0 one cycle later. No NAK response exists.
- R4: An OUT token while not live yields `rx_drop_o`=1 and `rx_accept_o`=0 one cycle later.
- R5: While live, an IN token yields `tx_data_o`=1 and an OUT token yields `rx_accept_o`=1, each one cycle later.
- R6: When the packet completions in a live frame reach the packets-per-frame count, `retire_o` pulses for exactly one cycle, in the cycle after the last completion. The endpoint returns to idle.
- R7: A start-of-frame that arrives while live, after a token or completion in the current frame and before the count is met, retires the descriptor. In the retire cycle the status has bit 0 (transaction error) and bit 1 (fulfillment error) set.
- R8: A live descriptor that sees no token and no completion stays live across any number of start-of-frame pulses, with no timeout.
- R9: A completion flagged with a CRC error is not retried. It still counts toward the per-frame count, and the retire status has bit 0 and bit 2 (CRC error) set with bit 1 clear.
- R10: Status bits [LEN_W+2:3] hold the residual length: the captured length minus the byte counts of all completions, saturating at zero.
- R11: A prime with packets-per-frame count 0 is ignored (the endpoint stays idle) and `cfg_err_o` pulses for one cycle.
- R12: `cancel_i` returns a pending or live endpoint to idle at the next clock edge without a retire strobe.
- R13: A prime while pending or live is ignored: `prime_bit_o` stays low and the descriptor in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prime_i | input | 1 | Software prime strobe |
| cancel_i | input | 1 | Synchronous cancel of pending or live descriptor |
| mult_i | input | 2 | Descriptor packets-per-frame count |
| len_i | input | LEN_W | Descriptor transfer length in bytes |
| sof_i | input | 1 | Start-of-frame pulse |
| in_tok_i | input | 1 | IN token received |
| out_tok_i | input | 1 | OUT token received |
| pkt_done_i | input | 1 | Packet completed |
| crc_err_i | input | 1 | Completed packet had a CRC error |
| pkt_bytes_i | input | LEN_W | Byte count of the completed packet |
| tx_data_o | output | 1 | Send descriptor data |
| tx_zlp_o | output | 1 | Send zero-length packet |
| rx_accept_o | output | 1 | Store received data |
| rx_drop_o | output | 1 | Discard received packet |
| prime_bit_o | output | 1 | Visible prime bit |
| pend_o | output | 1 | Descriptor waiting for a frame boundary |
| active_o | output | 1 | Descriptor live in the current frame |
| cfg_err_o | output | 1 | Prime rejected for zero count |
| retire_o | output | 1 | Descriptor retired (one-cycle pulse) |
| status_o | output | LEN_W+3 | Retire status: error bits and residual length |

## Verification
A corrupted packet counter shows up as a retire strobe one completion early or late. Such a counter also fails to raise the error bits, or raises them wrongly, at the next start-of-frame. The bench places completions and frame boundaries so that an off-by-one lands on a checked cycle. A state register stuck in pending or live turns zero-length replies into data replies, or data replies into drops. This shows up one cycle after the next token. A lost started flag lets a partial frame pass a boundary without the fulfillment error.

// File: rtl/iso_sched_pkg.sv
package iso_sched_pkg;
  localparam int unsigned MULT_W = 2;

  typedef enum logic [1:0] {
    EP_IDLE = 2'd0,
    EP_PEND = 2'd1,
    EP_LIVE = 2'd2
  } ep_state_e;

  // status word bit positions
  localparam int unsigned ST_XERR  = 0;
  localparam int unsigned ST_FULF  = 1;
  localparam int unsigned ST_CRC   = 2;
  localparam int unsigned ST_RESID = 3;
endpackage

// File: rtl/iso_prime_ctl.sv
module iso_prime_ctl
  import iso_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prime_i,
  input  logic              cancel_i,
  input  logic              sof_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              retire_now_i,
  output ep_state_e         state_o,
  output logic              prime_bit_o,
  output logic              cfg_err_o,
  output logic              capture_o,
  output logic              arm_o
);
  ep_state_e state_q, state_d;
  logic      illegal;

  always_comb begin
    capture_o = (state_q == EP_IDLE) && prime_i && (mult_i != '0) && !cancel_i;
    illegal   = (state_q == EP_IDLE) && prime_i && (mult_i == '0);
    arm_o     = (state_q == EP_PEND) && sof_i && !cancel_i;
    state_d   = state_q;
    if (cancel_i) begin
      state_d = EP_IDLE;
    end else begin
      unique case (state_q)
        EP_IDLE: if (capture_o)    state_d = EP_PEND;
        EP_PEND: if (sof_i)        state_d = EP_LIVE;
        EP_LIVE: if (retire_now_i) state_d = EP_IDLE;
        default:                   state_d = EP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= EP_IDLE;
      prime_bit_o <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      prime_bit_o <= capture_o;
      cfg_err_o   <= illegal;
    end
  end

  assign state_o = state_q;

  p_prime_bit_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prime_bit_o |=> !prime_bit_o);
  p_pend_waits_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EP_PEND) && !sof_i && !cancel_i |=> state_q == EP_PEND);
  p_illegal_mult_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EP_IDLE) && prime_i && (mult_i == '0) |=> cfg_err_o && state_q == EP_IDLE);
  p_cancel_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> state_q == EP_IDLE && !prime_bit_o);
  p_busy_prime_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != EP_IDLE) && prime_i |=> !prime_bit_o);
endmodule

// File: rtl/iso_pkt_cnt.sv
module iso_pkt_cnt
  import iso_sched_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              arm_i,
  input  logic              live_i,
  input  logic              tok_i,
  input  logic              done_i,
  input  logic              crc_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  bytes_i,
  output logic              last_o,
  output logic              started_o,
  output logic [LEN_W-1:0]  resid_nx_o,
  output logic              crc_nx_o
);
  logic [MULT_W-1:0] mult_q, cnt_q, cnt_d;
  logic [LEN_W-1:0]  resid_q, resid_d;
  logic              crc_q, crc_d, started_q, started_d;
  logic              live_done;

  always_comb begin
    live_done = live_i && done_i;
    last_o    = live_done && (cnt_q == MULT_W'(1));
    cnt_d     = cnt_q;
    resid_d   = resid_q;
    crc_d     = crc_q;
    started_d = started_q;
    if (capture_i) resid_d = len_i;
    if (arm_i) begin
      cnt_d     = mult_q;
      crc_d     = 1'b0;
      started_d = 1'b0;
    end else if (live_i) begin
      if (tok_i || done_i) started_d = 1'b1;
      if (done_i) begin
        cnt_d   = cnt_q - MULT_W'(1);
        resid_d = (bytes_i >= resid_q) ? '0 : resid_q - bytes_i;
        crc_d   = crc_q | crc_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q    <= '0;
      cnt_q     <= '0;
      resid_q   <= '0;
      crc_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (capture_i) mult_q <= mult_i;
      cnt_q     <= cnt_d;
      resid_q   <= resid_d;
      crc_q     <= crc_d;
      started_q <= started_d;
    end
  end

  assign started_o  = started_q;
  assign resid_nx_o = live_done ? resid_d : resid_q;
  assign crc_nx_o   = live_done ? crc_d : crc_q;

  p_cnt_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_i |-> cnt_q != '0);
  p_resid_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live_i && !capture_i |=> resid_q <= $past(resid_q));
endmodule

// File: rtl/iso_tok_resp.sv
module iso_tok_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic in_tok_i,
  input  logic out_tok_i,
  output logic tx_data_o,
  output logic tx_zlp_o,
  output logic rx_accept_o,
  output logic rx_drop_o
);
  logic tx_data_d, tx_zlp_d, rx_acc_d, rx_drop_d;

  always_comb begin
    tx_data_d = in_tok_i && live_i;
    tx_zlp_d  = in_tok_i && !live_i;
    rx_acc_d  = out_tok_i && live_i;
    rx_drop_d = out_tok_i && !live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data_o   <= 1'b0;
      tx_zlp_o    <= 1'b0;
      rx_accept_o <= 1'b0;
      rx_drop_o   <= 1'b0;
    end else begin
      tx_data_o   <= tx_data_d;
      tx_zlp_o    <= tx_zlp_d;
      rx_accept_o <= rx_acc_d;
      rx_drop_o   <= rx_drop_d;
    end
  end

  p_idle_in_zlp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok_i && !live_i |=> tx_zlp_o && !tx_data_o);
  p_idle_out_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_tok_i && !live_i |=> rx_drop_o && !rx_accept_o);
  p_live_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok_i && live_i |=> tx_data_o && !tx_zlp_o);
  p_tx_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_data_o, tx_zlp_o}));
endmodule

// File: rtl/iso_ep_sched.sv
module iso_ep_sched
  import iso_sched_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  localparam int unsigned ST_W = LEN_W + ST_RESID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prime_i,
  input  logic              cancel_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              sof_i,
  input  logic              in_tok_i,
  input  logic              out_tok_i,
  input  logic              pkt_done_i,
  input  logic              crc_err_i,
  input  logic [LEN_W-1:0]  pkt_bytes_i,
  output logic              tx_data_o,
  output logic              tx_zlp_o,
  output logic              rx_accept_o,
  output logic              rx_drop_o,
  output logic              prime_bit_o,
  output logic              pend_o,
  output logic              active_o,
  output logic              cfg_err_o,
  output logic              retire_o,
  output logic [ST_W-1:0]   status_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  ep_state_e        state;
  logic             capture, arm, live, last, started, crc_nx;
  logic             retire_now, fulfil;
  logic [LEN_W-1:0] resid_nx;
  logic [ST_W-1:0]  status_d, status_q;
  logic             retire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign live = (state == EP_LIVE);

  iso_prime_ctl u_prime (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .prime_i      (prime_i),
    .cancel_i     (cancel_i),
    .sof_i        (sof_i),
    .mult_i       (mult_i),
    .retire_now_i (retire_now),
    .state_o      (state),
    .prime_bit_o  (prime_bit_o),
    .cfg_err_o    (cfg_err_o),
    .capture_o    (capture),
    .arm_o        (arm)
  );

  iso_pkt_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .capture_i  (capture),
    .arm_i      (arm),
    .live_i     (live),
    .tok_i      (in_tok_i | out_tok_i),
    .done_i     (pkt_done_i),
    .crc_i      (crc_err_i),
    .mult_i     (mult_i),
    .len_i      (len_i),
    .bytes_i    (pkt_bytes_i),
    .last_o     (last),
    .started_o  (started),
    .resid_nx_o (resid_nx),
    .crc_nx_o   (crc_nx)
  );

  iso_tok_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .live_i      (live),
    .in_tok_i    (in_tok_i),
    .out_tok_i   (out_tok_i),
    .tx_data_o   (tx_data_o),
    .tx_zlp_o    (tx_zlp_o),
    .rx_accept_o (rx_accept_o),
    .rx_drop_o   (rx_drop_o)
  );

  always_comb begin
    fulfil     = live && sof_i && started && !last;
    retire_now = live && !cancel_i && (last || fulfil);
    status_d             = '0;
    status_d[ST_XERR]    = crc_nx || fulfil;
    status_d[ST_FULF]    = fulfil;
    status_d[ST_CRC]     = crc_nx;
    status_d[ST_W-1:ST_RESID] = resid_nx;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      retire_q <= 1'b0;
      status_q <= '0;
    end else begin
      retire_q <= retire_now;
      if (retire_now) status_q <= status_d;
    end
  end

  assign retire_o = retire_q;
  assign status_o = status_q;
  assign pend_o   = (state == EP_PEND);
  assign active_o = live;

  p_retire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    retire_o |=> !retire_o);
  p_retire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    retire_o |-> !active_o && !pend_o);
  p_fulfil_xerr_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    retire_o && status_o[ST_FULF] |-> status_o[ST_XERR]);
  p_quiet_live_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    live && !started && !cancel_i && !in_tok_i && !out_tok_i && !pkt_done_i |=> active_o);
  p_cancel_noret_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    cancel_i |=> !retire_o);
endmodule

// File: tb/iso_ep_sched_bench.sv
module iso_ep_sched_bench;
  localparam int LEN_W = 11;
  localparam int ST_W  = LEN_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prime_i = 0, cancel_i = 0, sof_i = 0, in_tok_i = 0, out_tok_i = 0;
  logic pkt_done_i = 0, crc_err_i = 0;
  logic [1:0] mult_i = 0;
  logic [LEN_W-1:0] len_i = 0, pkt_bytes_i = 0;
  logic tx_data_o, tx_zlp_o, rx_accept_o, rx_drop_o, prime_bit_o;
  logic pend_o, active_o, cfg_err_o, retire_o;
  logic [ST_W-1:0] status_o;

  int total = 0;
  int fails = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  iso_ep_sched #(.LEN_W(LEN_W)) u_iso_ep_sched (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    prime_i = 0; cancel_i = 0; sof_i = 0; in_tok_i = 0; out_tok_i = 0;
    pkt_done_i = 0; crc_err_i = 0;
  endtask

  task automatic do_prime(int m, int l);
    prime_i = 1; mult_i = 2'(m); len_i = LEN_W'(l); step();
  endtask
  task automatic do_sof;  sof_i = 1; step(); endtask
  task automatic do_in;   in_tok_i = 1; step(); endtask
  task automatic do_out;  out_tok_i = 1; step(); endtask
  task automatic do_done(int b, bit c);
    pkt_done_i = 1; pkt_bytes_i = LEN_W'(b); crc_err_i = c; step();
  endtask

  function automatic int resid(logic [ST_W-1:0] s);
    return int'(s[ST_W-1:3]);
  endfunction

  task automatic t_reset;
    chk("R1 reset pend", pend_o, 0);
    chk("R2 reset active", active_o, 0);
    chk("R6 reset retire", retire_o, 0);
    chk("R1 reset prime bit", prime_bit_o, 0);
  endtask

  task automatic t_unprimed;
    do_in();
    chk("R3 idle IN zlp", tx_zlp_o, 1);
    chk("R3 idle IN no data", tx_data_o, 0);
    do_out();
    chk("R4 idle OUT drop", rx_drop_o, 1);
    chk("R4 idle OUT no accept", rx_accept_o, 0);
  endtask

  task automatic t_illegal;
    do_prime(0, 10);
    chk("R11 cfg err pulse", cfg_err_o, 1);
    chk("R11 stays idle", pend_o, 0);
    chk("R11 no prime bit", prime_bit_o, 0);
    step();
    chk("R11 cfg err one cycle", cfg_err_o, 0);
  endtask

  task automatic t_full_frame;
    prime_i = 1; sof_i = 1; mult_i = 2; len_i = 100; step();
    chk("R1 pending", pend_o, 1);
    chk("R1 prime bit set", prime_bit_o, 1);
    chk("R2 same-cycle sof ignored", active_o, 0);
    do_in();
    chk("R1 prime bit cleared", prime_bit_o, 0);
    chk("R2 pending IN zlp", tx_zlp_o, 1);
    do_sof();
    chk("R2 live after sof", active_o, 1);
    do_in();
    chk("R5 live IN data", tx_data_o, 1);
    chk("R5 live IN no zlp", tx_zlp_o, 0);
    do_done(40, 0);
    chk("R6 no early retire", retire_o, 0);
    do_in();
    do_done(60, 0);
    chk("R6 retire after mult", retire_o, 1);
    chk("R6 xerr clear", status_o[0], 0);
    chk("R10 resid zero", resid(status_o), 0);
    chk("R6 back idle", active_o, 0);
    step();
    chk("R6 retire one cycle", retire_o, 0);
  endtask

  task automatic t_hold_crc;
    do_prime(1, 50);
    do_sof();
    do_sof();
    do_sof();
    do_sof();
    chk("R8 live across idle frames", active_o, 1);
    chk("R8 no retire", retire_o, 0);
    do_prime(3, 7);
    chk("R13 busy prime ignored", prime_bit_o, 0);
    do_out();
    chk("R5 live OUT accept", rx_accept_o, 1);
    do_done(20, 1);
    chk("R9 retire despite crc", retire_o, 1);
    chk("R9 xerr set", status_o[0], 1);
    chk("R9 crc bit", status_o[2], 1);
    chk("R9 no fulfil", status_o[1], 0);
    chk("R10 resid 30", resid(status_o), 30);
  endtask

  task automatic t_fulfil;
    do_prime(3, 300);
    do_sof();
    do_in();
    do_done(100, 0);
    chk("R7 no retire mid frame", retire_o, 0);
    do_sof();
    chk("R7 retire at boundary", retire_o, 1);
    chk("R7 xerr", status_o[0], 1);
    chk("R7 fulfil bit", status_o[1], 1);
    chk("R10 resid 200", resid(status_o), 200);
    chk("R7 idle after", active_o, 0);
  endtask

  task automatic t_saturate;
    do_prime(1, 10);
    do_sof();
    do_done(25, 0);
    chk("R10 saturate retire", retire_o, 1);
    chk("R10 resid saturates", resid(status_o), 0);
  endtask

  task automatic t_cancel;
    do_prime(2, 64);
    cancel_i = 1; step();
    chk("R12 cancel pending", pend_o, 0);
    do_sof();
    chk("R12 no live after cancel", active_o, 0);
    do_prime(2, 64);
    do_sof();
    do_in();
    cancel_i = 1; step();
    chk("R12 cancel live", active_o, 0);
    chk("R12 no retire", retire_o, 0);
    do_in();
    chk("R12 IN after cancel zlp", tx_zlp_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unprimed();
    t_illegal();
    t_full_frame();
    t_hold_crc();
    t_fulfil();
    t_saturate();
    t_cancel();
    repeat (2) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule